// File: doc/BRIEF.md
# PWM Timer Channel with Prescaler

This block is one PWM-capable timer channel. A free-running 16-bit up-counter advances on pulses from a programmable prescaler. It wraps to zero after it reaches the programmed period. A compare against a duty value shapes one output pin.

Each period opens in the inactive phase. The pin turns active once the count reaches the duty value and stays active up to the wrap. A duty value larger than the period therefore parks the pin at its inactive level. A polarity bit chooses which electrical level counts as active.

Software configures the channel through a plain single-cycle write port. Every write lands on the next clock edge. A separate counter-enable pin starts and stops counting. There is no data stream, so the port has no valid/ready handshake and no back-pressure. A write is accepted on every cycle that `wr_en` is high.

Disabling the output can be abrupt or graceful. An abrupt disable forces the inactive level at once. A graceful disable lets the current period run to its end first. The output enable should be cleared before the counter enable is dropped. That way the pin settles at its inactive level.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset the control, period, duty and count registers are zero, and `pwm_o` is low. While the output enable is zero the pin stays low even when counting.
- R2: On a cycle with `wr_en` high, the write takes effect on the next rising edge, and `wr_addr` selects the target:
  - 0 selects control.
  - 1 selects period.
  - 2 selects duty.
  - 3 selects count.

  The control fields are:
  - `wr_data[2:0]`: divider select.
  - bit 3: output enable.
  - bit 4: active-low.
  - bit 5: abrupt-off.

  Writing the count overrides that cycle's advance, and writing zero restarts the period.
- R3: The prescaler lets the counter advance once every 4^s clock cycles for divider select s from 0 to 5, which gives ratios of 1, 4, 16, 64, 256 and 1024. Selects 6 and 7 behave as 5.
- R4: On a prescaled tick the counter goes to zero if it equals the period, and otherwise it increments. One cycle therefore spans period+1 ticks. A period of 0xFFFF is supported.
- R5: With duty D ≤ period P and ratio r, each period shows D·r cycles inactive first and then (P−D+1)·r cycles active. With D = 0 the pin is active for the whole period.
- R6: With duty greater than period, the pin never goes active.
- R7: With active-low clear, the active level is high. With it set, the active level is low and the idle level is high.
- R8: With abrupt-off set, clearing the output enable makes the pin inactive in the cycle right after the write edge.
- R9: With abrupt-off clear, clearing the output enable lets the current period finish. The pin follows the compare until the counter wraps, and it is inactive from then on.
- R10: While `cnt_en` is low the counter holds its value and the prescaler divider is cleared. After `cnt_en` rises, the first advance comes after a full 4^s cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable; low freezes the count and clears the divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 count |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | PWM output pin |

## Verification
The pin is a combinational function of the registered count, compare values and control. Every register write, and every counter advance, therefore shows up on `pwm_o` in the cycle that follows the rising edge that stored it. The bench drives inputs just after a falling edge and samples at the next falling edge.

The first counter advance lands exactly 4^s edges after `cnt_en` rises. The bench raises `cnt_en` at a known falling edge. Sample k then reflects count ⌊k/4^s⌋. This lets it sum active samples over two whole periods and check the exact cycle on either side of the inactive-to-active switch.

For the disable tests the write edge is counted as edge 1. The graceful case expects the pin to fall at the wrap edge, which is edge P+1.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef struct packed {
    logic       abrupt;
    logic       act_low;
    logic       out_en;
    logic [2:0] div_sel;
  } chan_ctrl_t;

  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_PER   = 2'd1,
    ADDR_DUTY  = 2'd2,
    ADDR_COUNT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 2 * MAX_SEL;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] term_tbl [MAX_SEL+1];
  logic [DIV_W-1:0] term;
  logic [SEL_W-1:0] sel_c;

  for (genvar g = 0; g <= MAX_SEL; g++) begin : g_term
    localparam int TERM = (1 << (2 * g)) - 1;
    assign term_tbl[g] = DIV_W'(TERM);
  end

  assign sel_c = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
  assign term  = term_tbl[sel_c];
  assign tick  = run && (div_q >= term);

  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0)); // R10
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = tick && !load && (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (wrap)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt == period) |=> (cnt == '0)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt)); // R10
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_en,
  input  logic         act_low,
  input  logic         abrupt,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] period,
  input  logic         wrap,
  output logic         pin
);
  logic linger_q;
  logic drive;
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n)                 linger_q <= 1'b0;
    else if (out_en)            linger_q <= 1'b1;
    else if (abrupt || wrap)    linger_q <= 1'b0;
  end

  assign drive  = out_en || (linger_q && !abrupt);
  assign active = drive && (duty <= period) && (cnt >= duty);
  assign pin    = active ^ act_low;

  AST_DUTY_OVER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (duty > period) |-> (pin == act_low)); // R6
  AST_ABRUPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && abrupt) |-> (pin == act_low)); // R8
  AST_LINGER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && wrap) |=> (out_en || pin == act_low)); // R9
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int W       = 16,
  parameter int MAX_SEL = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [15:0]  wr_data,
  output logic         pwm_o
);
  chan_ctrl_t   ctrl_q;
  logic [W-1:0] per_q;
  logic [W-1:0] duty_q;
  logic [W-1:0] cnt;
  logic         tick;
  logic         wrap;
  logic         load;

  assign load = wr_en && (wr_addr == ADDR_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl_q <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_PER:  per_q  <= W'(wr_data);
        ADDR_DUTY: duty_q <= W'(wr_data);
        default:   ;
      endcase
    end
  end

  pwm_prescaler #(.SEL_W(3), .MAX_SEL(MAX_SEL)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(cnt_en), .sel(ctrl_q.div_sel), .tick(tick)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(W'(wr_data)), .period(per_q), .cnt(cnt), .wrap(wrap)
  );

  pwm_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .out_en(ctrl_q.out_en), .act_low(ctrl_q.act_low),
    .abrupt(ctrl_q.abrupt), .cnt(cnt), .duty(duty_q), .period(per_q),
    .wrap(wrap), .pin(pwm_o)
  );

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_DUTY) |=> (duty_q == $past(W'(wr_data)))); // R2
endmodule

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_timer_chan u_pwm_timer_chan (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk_ctrl(input int sel, input bit en,
                                          input bit al, input bit ab);
    return {10'd0, ab, al, en, 3'(sel)};
  endfunction

  task automatic run_cfg(input int sel, input int p, input int d, input bit al);
    int r;
    int n;
    int hi;
    int exp_hi;
    int eff;
    int edge_lo;
    int edge_hi;
    eff = (sel > 5) ? 5 : sel;
    r = 1 << (2 * eff);
    n = (p + 1) * r * 2;
    cnt_en = 1'b0;
    wr(2'd0, mk_ctrl(sel, 1'b1, al, 1'b1));
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(d));
    wr(2'd3, 16'd0);
    cnt_en = 1'b1;
    hi = 0; edge_lo = -1; edge_hi = -1;
    for (int k = 0; k < n; k++) begin
      if (pwm_o != al) hi++;
      if (k == d * r - 1) edge_lo = (pwm_o != al);
      if (k == d * r)     edge_hi = (pwm_o != al);
      @(negedge clk);
    end
    cnt_en = 1'b0;
    exp_hi = (d <= p) ? (p - d + 1) * r * 2 : 0;
    if (sel > 5) chk($sformatf("R3 sel%0d clamps, active cycles", sel), hi, exp_hi);
    else if (d > p) chk($sformatf("R6 sel%0d d%0d never active", sel, d), hi, 0);
    else chk($sformatf("R5 sel%0d p%0d d%0d active cycles", sel, p, d), hi, exp_hi);
    if (d > 0 && d <= p) begin
      chk($sformatf("R5 sel%0d inactive before duty", sel), edge_lo, 0);
      chk($sformatf("R3 sel%0d active at duty*ratio", sel), edge_hi, 1);
    end
    wr(2'd0, mk_ctrl(sel, 1'b0, al, 1'b1));
    chk($sformatf("R7 idle level al=%0d", al), int'(pwm_o), int'(al));
  endtask

  initial begin
    #1900000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int duties [4];
    duties = '{0, 2, 5, 6};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset pin low", int'(pwm_o), 0);
    cnt_en = 1'b1;
    repeat (7) @(negedge clk);
    chk("R1 disabled while counting", int'(pwm_o), 0);
    cnt_en = 1'b0;

    for (int s = 0; s <= 5; s++)
      for (int i = 0; i < 4; i++)
        run_cfg(s, 5, duties[i], 1'(s + i));
    run_cfg(6, 5, 3, 1'b0);

    // R4: wrap at maximum period; duty at max means active only at 0xFFFF
    wr(2'd0, mk_ctrl(0, 1'b1, 1'b0, 1'b1));
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFE);
    cnt_en = 1'b1;
    chk("R4 count 0xFFFE inactive", int'(pwm_o), 0);
    @(negedge clk);
    chk("R4 count 0xFFFF active", int'(pwm_o), 1);
    @(negedge clk);
    chk("R4 wrapped to zero inactive", int'(pwm_o), 0);
    cnt_en = 1'b0;

    // R9: graceful disable finishes the period
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd0);
    wr(2'd0, mk_ctrl(0, 1'b1, 1'b0, 1'b0));
    wr(2'd3, 16'd0);
    cnt_en = 1'b1;
    wr(2'd0, mk_ctrl(0, 1'b0, 1'b0, 1'b0));
    chk("R9 still active after clear", int'(pwm_o), 1);
    repeat (4) @(negedge clk);
    chk("R9 active at last count", int'(pwm_o), 1);
    @(negedge clk);
    chk("R9 inactive after wrap", int'(pwm_o), 0);
    @(negedge clk);
    chk("R9 stays inactive", int'(pwm_o), 0);
    cnt_en = 1'b0;

    // R8: abrupt disable
    wr(2'd0, mk_ctrl(0, 1'b1, 1'b0, 1'b1));
    wr(2'd3, 16'd0);
    cnt_en = 1'b1;
    chk("R8 active before clear", int'(pwm_o), 1);
    wr(2'd0, mk_ctrl(0, 1'b0, 1'b0, 1'b1));
    chk("R8 inactive at once", int'(pwm_o), 0);
    cnt_en = 1'b0;

    // R10: freeze while counter enable is low
    wr(2'd2, 16'd3);
    wr(2'd0, mk_ctrl(0, 1'b1, 1'b0, 1'b1));
    wr(2'd3, 16'd0);
    cnt_en = 1'b1;
    repeat (2) @(negedge clk);
    cnt_en = 1'b0;
    repeat (9) @(negedge clk);
    chk("R10 frozen count stays inactive", int'(pwm_o), 0);
    cnt_en = 1'b1;
    @(negedge clk);
    chk("R10 resumes to duty", int'(pwm_o), 1);
    cnt_en = 1'b0;

    // R2: write count mid-period restarts
    wr(2'd3, 16'd0);
    chk("R2 count write restarts period", int'(pwm_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule